// File: doc/BRIEF.md
# Sequential Sign-Magnitude Multiplier

The block multiplies two sign-magnitude numbers one bit per clock. One factor sits in the multiplier-quotient register, which is loaded through its own load path while the block is idle. The other factor arrives with the start strobe. Each step looks at the lowest multiplier-quotient bit and, when that bit is 1, adds the operand magnitude into the accumulator. The accumulator and the multiplier-quotient register then shift right together as one double-width register. After the last step the high half of the product is in the accumulator and the low half is in the multiplier-quotient register.

A start with a zero operand magnitude skips the iteration and clears both magnitudes at once. When round-select is high at start, one extra cycle adds the top magnitude bit of the multiplier-quotient register into the accumulator. Both registers carry the product sign, which is the exclusive-or of the operand sign and the sign held in the multiplier-quotient register. A busy level and a one-cycle done pulse tell the surrounding sequencer when the result is ready.

Top module: `sm_multiplier`

## Requirements
- R1: After reset, busy and done are 0, and both magnitudes and both signs are 0.
- R2: When the block is idle and start is low, a high mq_load writes mq_load_sign and mq_load_mag into the multiplier-quotient register, visible on the next cycle. mq_load is ignored while busy, and also when start is high in the same cycle.
- R3: A start with a nonzero operand magnitude that is accepted while idle clears the accumulator. busy then rises on the next cycle and stays high for exactly MAG_W cycles (35 by default) when round-select is low.
- R4: Without rounding, at done the concatenation {ac_mag, mq_mag} equals the operand magnitude times the multiplier-quotient magnitude held at start.
- R5: A start with operand magnitude 0 never raises busy. done is high on the next cycle, and ac_mag and mq_mag are both 0.
- R6: With round-select high at start, busy lasts MAG_W+1 cycles. In the extra cycle ac_mag increases by 1 exactly when bit MAG_W-1 of mq_mag is 1, and mq_mag is not changed.
- R7: From the cycle after an accepted start, ac_sign and mq_sign both equal the operand sign XOR the multiplier-quotient sign held at start. They stay constant while busy.
- R8: done is a single-cycle pulse that is only high while busy is low.
- R9: A start strobe received while busy is ignored. The running result, its duration and its signs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| round_sel | input | 1 | Select the rounding variant for this operation |
| opd_sign | input | 1 | Operand sign (1 = negative) |
| opd_mag | input | MAG_W | Operand magnitude |
| mq_load | input | 1 | Load strobe for the multiplier-quotient register |
| mq_load_sign | input | 1 | Sign written by mq_load |
| mq_load_mag | input | MAG_W | Magnitude written by mq_load |
| ac_sign | output | 1 | Accumulator sign |
| ac_mag | output | MAG_W | Accumulator magnitude (high product half) |
| mq_sign | output | 1 | Multiplier-quotient sign |
| mq_mag | output | MAG_W | Multiplier-quotient magnitude (low product half) |
| busy | output | 1 | Iteration or rounding in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The assertions check the handshake on every cycle: the busy length for each variant, the single-cycle done pulse that never overlaps busy, the zero-operand shortcut, the sign hold, and the way the rounding cycle changes the accumulator while leaving the multiplier-quotient register alone. They do not check the arithmetic value of the product. Only the bench's sweeps over every magnitude pair of a 5-bit configuration show that. The sweeps cover both sign combinations in turn, both rounding modes, strobes injected in the middle of a run, and a load that collides with start.

// File: rtl/sm_mul_pkg.sv
package sm_mul_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_RND  = 2'd2
  } mul_phase_e;

  // Sign of a sign-magnitude product.
  function automatic logic prod_sign_f(input logic s_a, input logic s_b);
    return s_a ^ s_b;
  endfunction

endpackage

// File: rtl/sm_mul_step.sv
// One shift-and-add step over the double-width {ac, mq} register.
module sm_mul_step #(
  parameter int MAG_W = 35
) (
  input  logic [MAG_W-1:0] ac_in,
  input  logic [MAG_W-1:0] mq_in,
  input  logic [MAG_W-1:0] addend,
  output logic [MAG_W-1:0] ac_out,
  output logic [MAG_W-1:0] mq_out
);
  localparam int SUM_W = MAG_W + 1;

  function automatic logic [SUM_W-1:0] add_f(input logic [MAG_W-1:0] a,
                                             input logic [MAG_W-1:0] b,
                                             input logic             en);
    logic [SUM_W-1:0] s;
    s = {1'b0, a} + (en ? {1'b0, b} : '0);
    return s;
  endfunction

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = add_f(ac_in, addend, mq_in[0]);
    ac_out = sum[SUM_W-1:1];
    mq_out = {sum[0], mq_in[MAG_W-1:1]};
  end
endmodule

// File: rtl/sm_mul_ctrl.sv
// Phase sequencer: step counter, busy level, done pulse.
module sm_mul_ctrl
  import sm_mul_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic round_sel,
  input  logic opd_zero,
  output logic accept,
  output logic zero_fire,
  output logic step_en,
  output logic round_fire,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(MAG_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAG_W - 1);

  mul_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rnd_q, rnd_d;
  logic             done_d;
  logic             last_step;

  always_comb begin
    accept     = (phase_q == PH_IDLE) && start;
    zero_fire  = accept && opd_zero;
    step_en    = (phase_q == PH_RUN);
    round_fire = (phase_q == PH_RND);
    last_step  = step_en && (cnt_q == LAST_CNT);
    busy       = (phase_q != PH_IDLE);

    phase_d = phase_q;
    cnt_d   = cnt_q;
    rnd_d   = rnd_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (zero_fire) begin
          done_d = 1'b1;
        end else if (accept) begin
          phase_d = PH_RUN;
          cnt_d   = '0;
          rnd_d   = round_sel;
        end
      end
      PH_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) begin
          if (rnd_q) begin
            phase_d = PH_RND;
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      PH_RND: begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rnd_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rnd_q   <= rnd_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/sm_mul_regs.sv
// Accumulator, multiplier-quotient register and captured operand.
module sm_mul_regs
  import sm_mul_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             zero_fire,
  input  logic             step_en,
  input  logic             round_fire,
  input  logic             busy,
  input  logic             opd_sign,
  input  logic [MAG_W-1:0] opd_mag,
  input  logic             mq_load,
  input  logic             mq_load_sign,
  input  logic [MAG_W-1:0] mq_load_mag,
  output logic             ac_sign,
  output logic [MAG_W-1:0] ac_mag,
  output logic             mq_sign,
  output logic [MAG_W-1:0] mq_mag
);
  logic [MAG_W-1:0] opd_q;
  logic [MAG_W-1:0] ac_step, mq_step;
  logic [MAG_W-1:0] ac_rnd;
  logic             load_ok;

  sm_mul_step #(.MAG_W(MAG_W)) u_step (
    .ac_in  (ac_mag),
    .mq_in  (mq_mag),
    .addend (opd_q),
    .ac_out (ac_step),
    .mq_out (mq_step)
  );

  always_comb begin
    ac_rnd  = ac_mag + {{(MAG_W-1){1'b0}}, mq_mag[MAG_W-1]};
    load_ok = mq_load && !busy && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_sign <= 1'b0;
      ac_mag  <= '0;
      mq_sign <= 1'b0;
      mq_mag  <= '0;
      opd_q   <= '0;
    end else begin
      if (accept) begin
        ac_sign <= prod_sign_f(opd_sign, mq_sign);
        mq_sign <= prod_sign_f(opd_sign, mq_sign);
        ac_mag  <= '0;
        opd_q   <= opd_mag;
        if (zero_fire) mq_mag <= '0;
      end else if (load_ok) begin
        mq_sign <= mq_load_sign;
        mq_mag  <= mq_load_mag;
      end else if (step_en) begin
        ac_mag <= ac_step;
        mq_mag <= mq_step;
      end else if (round_fire) begin
        ac_mag <= ac_rnd;
      end
    end
  end
endmodule

// File: rtl/sm_multiplier.sv
module sm_multiplier #(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             round_sel,
  input  logic             opd_sign,
  input  logic [MAG_W-1:0] opd_mag,
  input  logic             mq_load,
  input  logic             mq_load_sign,
  input  logic [MAG_W-1:0] mq_load_mag,
  output logic             ac_sign,
  output logic [MAG_W-1:0] ac_mag,
  output logic             mq_sign,
  output logic [MAG_W-1:0] mq_mag,
  output logic             busy,
  output logic             done
);
  // Named internal events, exposed for the bound checker.
  logic accept_w, zero_fire_w, step_w, round_fire_w;
  logic opd_zero;

  assign opd_zero = (opd_mag == '0);

  sm_mul_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .round_sel  (round_sel),
    .opd_zero   (opd_zero),
    .accept     (accept_w),
    .zero_fire  (zero_fire_w),
    .step_en    (step_w),
    .round_fire (round_fire_w),
    .busy       (busy),
    .done       (done)
  );

  sm_mul_regs #(.MAG_W(MAG_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept_w),
    .zero_fire    (zero_fire_w),
    .step_en      (step_w),
    .round_fire   (round_fire_w),
    .busy         (busy),
    .opd_sign     (opd_sign),
    .opd_mag      (opd_mag),
    .mq_load      (mq_load),
    .mq_load_sign (mq_load_sign),
    .mq_load_mag  (mq_load_mag),
    .ac_sign      (ac_sign),
    .ac_mag       (ac_mag),
    .mq_sign      (mq_sign),
    .mq_mag       (mq_mag)
  );
endmodule

// File: rtl/sm_mul_chk.sv
module sm_mul_chk #(
  parameter int MAG_W = 35
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             round_sel,
  input logic [MAG_W-1:0] opd_mag,
  input logic             busy,
  input logic             done,
  input logic             ac_sign,
  input logic [MAG_W-1:0] ac_mag,
  input logic             mq_sign,
  input logic [MAG_W-1:0] mq_mag,
  input logic             accept_w,
  input logic             round_fire_w
);
  localparam int CNT_W = $clog2(MAG_W + 3);

  logic [CNT_W-1:0] busy_cnt;
  logic             rnd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      rnd_seen <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt + 1'b1;
      else      busy_cnt <= '0;
      if (start && !busy) rnd_seen <= round_sel;
    end
  end

  AST_RUN_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opd_mag != '0) |=> (busy && ac_mag == '0)); // R3

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(rnd_seen ? MAG_W + 1 : MAG_W))); // R6

  AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opd_mag == '0) |=> (!busy && done && ac_mag == '0 && mq_mag == '0)); // R5

  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    round_fire_w |=> (ac_mag == $past(ac_mag) + {{(MAG_W-1){1'b0}}, $past(mq_mag[MAG_W-1])}
                      && $stable(mq_mag))); // R6

  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ac_sign) && $stable(mq_sign))); // R7

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ac_sign == mq_sign)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_w); // R9
endmodule

bind sm_multiplier sm_mul_chk #(.MAG_W(MAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .round_sel    (round_sel),
  .opd_mag      (opd_mag),
  .busy         (busy),
  .done         (done),
  .ac_sign      (ac_sign),
  .ac_mag       (ac_mag),
  .mq_sign      (mq_sign),
  .mq_mag       (mq_mag),
  .accept_w     (accept_w),
  .round_fire_w (round_fire_w)
);

// File: tb/sim_sm_multiplier.sv
module sim_sm_multiplier;
  localparam int W       = 5;
  localparam int CLK_PER = 10;
  localparam int MAXV    = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, round_sel = 1'b0, opd_sign = 1'b0;
  logic [W-1:0] opd_mag = '0;
  logic         mq_load = 1'b0, mq_load_sign = 1'b0;
  logic [W-1:0] mq_load_mag = '0;
  logic         ac_sign, mq_sign, busy, done;
  logic [W-1:0] ac_mag, mq_mag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  sm_multiplier #(.MAG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .round_sel(round_sel),
    .opd_sign(opd_sign), .opd_mag(opd_mag), .mq_load(mq_load),
    .mq_load_sign(mq_load_sign), .mq_load_mag(mq_load_mag),
    .ac_sign(ac_sign), .ac_mag(ac_mag), .mq_sign(mq_sign), .mq_mag(mq_mag),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mq(input int a, input bit sa);
    @(negedge clk);
    mq_load = 1'b1; mq_load_sign = sa; mq_load_mag = W'(a);
    @(negedge clk);
    mq_load = 1'b0;
    chk(mq_mag == W'(a) && mq_sign == sa, "R2 load", int'(mq_mag), a);
  endtask

  // Runs one operation; mq already holds a with sign sa.
  task automatic run_op(input int a, input int b, input bit sa, input bit sb,
                        input bit rnd, input bit poke);
    int n;
    int guard;
    int p, hi, lo, exp_n;
    start = 1'b1; opd_sign = sb; opd_mag = W'(b); round_sel = rnd;
    @(negedge clk);
    start = 1'b0;
    n = 0; guard = 0;
    while (!done && guard < 4 * W) begin
      if (busy) n++;
      if (poke && n == 1) begin
        start = 1'b1; opd_mag = ~W'(b); opd_sign = ~sb; round_sel = ~rnd;
        mq_load = 1'b1; mq_load_mag = ~W'(a); mq_load_sign = ~sa;
      end
      @(negedge clk);
      start = 1'b0; mq_load = 1'b0;
      guard++;
    end
    p  = a * b;
    hi = p >> W;
    lo = p & (MAXV - 1);
    if (rnd && b != 0 && ((lo >> (W - 1)) & 1) == 1) hi = hi + 1;
    exp_n = (b == 0) ? 0 : (rnd ? W + 1 : W);
    chk(done == 1'b1, "R8 done seen", int'(done), 1);
    chk(busy == 1'b0, "R8 done while idle", int'(busy), 0);
    if (b == 0) chk(n == 0, "R5 no busy on zero operand", n, 0);
    else if (rnd) chk(n == exp_n, "R6 busy length with rounding", n, exp_n);
    else chk(n == exp_n, "R3 busy length", n, exp_n);
    if (b == 0) chk(ac_mag == 0 && mq_mag == 0, "R5 zero result", int'({ac_mag, mq_mag}), 0);
    else if (rnd) chk(ac_mag == W'(hi) && mq_mag == W'(lo), "R6 rounded product",
                      int'({ac_mag, mq_mag}), (hi << W) | lo);
    else chk(ac_mag == W'(hi) && mq_mag == W'(lo), "R4 product",
             int'({ac_mag, mq_mag}), (hi << W) | lo);
    chk(ac_sign == (sa ^ sb) && mq_sign == (sa ^ sb), "R7 product sign",
        int'({ac_sign, mq_sign}), (sa ^ sb) ? 3 : 0);
    if (poke) chk(n == exp_n, "R9 start while busy ignored", n, exp_n);
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset control", int'({busy, done}), 0);
    chk(ac_mag == 0 && mq_mag == 0 && ac_sign == 0 && mq_sign == 0, "R1 reset data",
        int'({ac_sign, ac_mag, mq_sign, mq_mag}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: load colliding with start is dropped; product uses the held value.
    load_mq(3, 1'b0);
    mq_load = 1'b1; mq_load_mag = W'(7); mq_load_sign = 1'b1;
    run_op(3, 5, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(ac_sign == 1'b0, "R2 load with start ignored", int'(ac_sign), 0);

    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < MAXV; a++) begin
        for (int b = 0; b < MAXV; b++) begin
          bit sa, sb, pk;
          sa = bit'((a ^ b) & 1);
          sb = bit'((a >> 1) & 1);
          pk = ((a + b) % 7) == 0;
          load_mq(a, sa);
          run_op(a, b, sa, sb, bit'(r), pk);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule